// File: doc/BRIEF.md
# Page Translation Buffer with Access Guard

This block turns a 32-bit virtual address into a physical address by searching a small, fully associative set of cached page translations. Pages are 8 KB. The low 13 address bits pass through unchanged. The upper 19 bits select a page, and that page is swapped for the frame number stored in the matching slot. Every request carries an access kind (read, write or execute) and a privilege flag that says whether the processor is running kernel or user code. The answer is either a physical address or a two-bit fault code.

The block holds eight slots and does not walk page tables. Privileged software writes new translations through a fill port, and each fill lands in the next slot in circular order. Software also pulses a flush input when the address space changes, which empties every slot. If a lookup finds no slot, it returns a miss fault so that software can load the translation and retry.

The top half of the address space belongs to the kernel. A user-mode request aimed there is refused whatever the slots hold. A request is accepted on a valid/ready handshake, and its answer appears on the following clock edge.

Top module: `vpage_xlate`

## Requirements
- R1: After reset, `rspValid` is 0 and `reqReady` is 1, and no slot holds a translation, so any kernel-mode lookup returns the miss fault.
- R2: `reqReady` is 0 in any cycle in which `fillEn` or `flushEn` is 1, and 1 otherwise. A request is accepted when `reqValid` and `reqReady` are both 1. `rspValid` is 1 in exactly the cycle after each accepted request.
- R3: A permitted hit returns `rspFault` = 0 and `rspPaddr` = {frame number of the slot, `reqVaddr[12:0]`}.
- R4: Access kinds are coded 0 = read, 1 = write, 2 = execute and 3 = reserved. Slot permission bits are bit 0 = read, bit 1 = write and bit 2 = execute. A hit whose kind is not permitted, or whose kind is the reserved code, returns `rspFault` = 2 (protection).
- R5: A lookup whose page number (`reqVaddr[31:13]`) matches no valid slot returns `rspFault` = 1 (miss).
- R6: A user-mode request (`reqKernel` = 0) with `reqVaddr[31]` = 1 returns `rspFault` = 3 (privilege). This check takes priority over miss and protection.
- R7: Fills go to slots 0, 1, 2 and onward, wrapping after the last slot. The ninth fill since reset therefore replaces the translation written by the first fill.
- R8: A flush invalidates every slot and returns the fill pointer to slot 0. When `flushEn` and `fillEn` are high in the same cycle, the flush wins and nothing is written.
- R9: Whenever `rspFault` is nonzero, `rspPaddr` is 0.
- R10: In kernel mode, both halves of the address space translate, and only the permission bits apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Lookup can be accepted this cycle |
| reqVaddr | input | 32 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| reqKernel | input | 1 | 1 = kernel mode, 0 = user mode |
| rspValid | output | 1 | Lookup answer present |
| rspPaddr | output | 32 | Physical address (0 on fault) |
| rspFault | output | 2 | 0 none, 1 miss, 2 protection, 3 privilege |
| fillEn | input | 1 | Write a translation into the next slot |
| fillVpn | input | 19 | Virtual page number to store |
| fillPfn | input | 19 | Physical frame number to store |
| fillPerm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| flushEn | input | 1 | Invalidate all slots |

## Verification
A slot whose valid flag, page number or permissions are stored wrongly shows at the ports on the very next lookup that touches that page. The answer, one cycle after acceptance, carries the wrong fault code or the wrong frame bits. A fill pointer that advances wrongly stays hidden until the ninth fill wraps onto an older slot. The bench therefore fills past the wrap, both after reset and after a flush, and probes both the evicted page and the surviving pages. Because every slot gets every access kind in both modes, a wrong permission decode or a wrong fault priority appears within one sweep.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_PROT = 2'd2,
    FLT_PRIV = 2'd3
  } fault_e;

  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic lookup;
    logic fill;
    logic flush;
  } strobe_t;

endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             fillEn,
  input  logic             flushEn,
  output logic             reqReady,
  output logic             rspValid,
  output strobe_t          strobe,
  output logic [PTR_W-1:0] fillIdx
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(ENTRIES - 1);

  logic maintBusy;

  always_comb begin
    maintBusy     = fillEn || flushEn;
    reqReady      = !maintBusy;
    strobe.lookup = reqValid && !maintBusy;
    strobe.flush  = flushEn;
    strobe.fill   = fillEn && !flushEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
    end else begin
      rspValid <= strobe.lookup;
    end
  end

  // circular fill pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillIdx <= '0;
    end else if (strobe.flush) begin
      fillIdx <= '0;
    end else if (strobe.fill) begin
      if (fillIdx == LAST_IDX) fillIdx <= '0;
      else                     fillIdx <= fillIdx + 1'b1;
    end
  end

endmodule

// File: rtl/xlate_data.sv
module xlate_data
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 13,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PFN_W  = PA_W - OFF_W,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [PTR_W-1:0]  fillIdx,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [PERM_W-1:0] fillPerm,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic              reqKernel,
  output logic [PA_W-1:0]   rspPaddr,
  output logic [1:0]        rspFault
);

  logic [VPN_W-1:0]  reqVpn;
  logic [ENTRIES-1:0] hitVec;
  logic [PFN_W-1:0]  slotPfn  [ENTRIES];
  logic [PERM_W-1:0] slotPerm [ENTRIES];

  assign reqVpn = reqVaddr[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    logic              entValid;
    logic [VPN_W-1:0]  entVpn;
    logic [PFN_W-1:0]  entPfn;
    logic [PERM_W-1:0] entPerm;
    logic              slotSel;

    assign slotSel = strobe.fill && (fillIdx == PTR_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid <= 1'b0;
      end else if (strobe.flush) begin
        entValid <= 1'b0;
      end else if (slotSel) begin
        entValid <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (slotSel) begin
        entVpn  <= fillVpn;
        entPfn  <= fillPfn;
        entPerm <= fillPerm;
      end
    end

    assign hitVec[g]   = entValid && (entVpn == reqVpn);
    assign slotPfn[g]  = entPfn;
    assign slotPerm[g] = entPerm;
  end

  // lowest matching slot wins
  logic [PFN_W-1:0]  selPfn;
  logic [PERM_W-1:0] selPerm;
  logic              anyHit;

  always_comb begin
    selPfn  = '0;
    selPerm = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selPfn  = slotPfn[i];
        selPerm = slotPerm[i];
      end
    end
    anyHit = |hitVec;
  end

  logic   permOk;
  logic   userHigh;
  fault_e faultNext;
  logic [PA_W-1:0] paddrNext;

  always_comb begin
    case (access_e'(reqAccess))
      ACC_READ:  permOk = selPerm[PERM_RD];
      ACC_WRITE: permOk = selPerm[PERM_WR];
      ACC_EXEC:  permOk = selPerm[PERM_EX];
      default:   permOk = 1'b0;
    endcase
  end

  always_comb begin
    userHigh = !reqKernel && reqVaddr[VA_W-1];
    if (userHigh)     faultNext = FLT_PRIV;
    else if (!anyHit) faultNext = FLT_MISS;
    else if (!permOk) faultNext = FLT_PROT;
    else              faultNext = FLT_NONE;
    if (faultNext == FLT_NONE) paddrNext = {selPfn, reqVaddr[OFF_W-1:0]};
    else                       paddrNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPaddr <= '0;
      rspFault <= FLT_NONE;
    end else if (strobe.lookup) begin
      rspPaddr <= paddrNext;
      rspFault <= faultNext;
    end
  end

endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 13,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PFN_W  = PA_W - OFF_W,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic              reqKernel,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPaddr,
  output logic [1:0]        rspFault,
  input  logic              fillEn,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [PERM_W-1:0] fillPerm,
  input  logic              flushEn
);

  strobe_t          strobe;
  logic [PTR_W-1:0] fillIdx;

  xlate_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .fillEn   (fillEn),
    .flushEn  (flushEn),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe),
    .fillIdx  (fillIdx)
  );

  xlate_data #(
    .ENTRIES (ENTRIES),
    .VA_W    (VA_W),
    .PA_W    (PA_W),
    .OFF_W   (OFF_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fillIdx   (fillIdx),
    .fillVpn   (fillVpn),
    .fillPfn   (fillPfn),
    .fillPerm  (fillPerm),
    .reqVaddr  (reqVaddr),
    .reqAccess (reqAccess),
    .reqKernel (reqKernel),
    .rspPaddr  (rspPaddr),
    .rspFault  (rspFault)
  );

endmodule

// File: rtl/xlate_props.sv
module xlate_props #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 13
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [VA_W-1:0] reqVaddr,
  input logic            reqKernel,
  input logic            rspValid,
  input logic [PA_W-1:0] rspPaddr,
  input logic [1:0]      rspFault,
  input logic            fillEn,
  input logic            flushEn
);

  logic accepted;
  assign accepted = reqValid && reqReady;

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn || flushEn) |-> !reqReady); // R2

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> rspValid); // R2

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> !rspValid); // R2

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> (rspFault != 2'd0) || (rspPaddr[OFF_W-1:0] == $past(reqVaddr[OFF_W-1:0]))); // R3

  AST_USER_HIGH_PRIV: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !reqKernel && reqVaddr[VA_W-1]) |=> (rspFault == 2'd3)); // R6

  AST_FLUSH_THEN_MISS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(flushEn) && accepted && reqKernel) |=> (rspFault == 2'd1)); // R8

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'd0) |-> (rspPaddr == '0)); // R9

endmodule

bind vpage_xlate xlate_props #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_props (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqVaddr  (reqVaddr),
  .reqKernel (reqKernel),
  .rspValid  (rspValid),
  .rspPaddr  (rspPaddr),
  .rspFault  (rspFault),
  .fillEn    (fillEn),
  .flushEn   (flushEn)
);

// File: tb/vpage_xlate_bench.sv
module vpage_xlate_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqKernel = 1'b0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic [1:0]  rspFault;
  logic        fillEn = 1'b0;
  logic [18:0] fillVpn = '0;
  logic [18:0] fillPfn = '0;
  logic [2:0]  fillPerm = '0;
  logic        flushEn = 1'b0;

  always #2 clk = ~clk;

  vpage_xlate u_vpage_xlate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .reqKernel(reqKernel),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault),
    .fillEn(fillEn), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillPerm(fillPerm), .flushEn(flushEn)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  // reference model
  logic [18:0] mVpn  [8];
  logic [18:0] mPfn  [8];
  logic [2:0]  mPerm [8];
  logic        mValid[8];
  int          mPtr = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] va, input logic [1:0] acc, input logic kern,
                                output logic [1:0] f, output logic [31:0] pa, output string tag);
    int  hit = -1;
    logic ok;
    for (int i = 7; i >= 0; i--)
      if (mValid[i] && mVpn[i] == va[31:13]) hit = i;
    pa = 32'h0;
    if (!kern && va[31]) begin
      f = 2'd3; tag = "R6";
    end else if (hit < 0) begin
      f = 2'd1; tag = "R5";
    end else begin
      ok = (acc == 2'd3) ? 1'b0 : mPerm[hit][acc];
      if (!ok) begin
        f = 2'd2; tag = "R4";
      end else begin
        f = 2'd0; pa = {mPfn[hit], va[12:0]};
        tag = (kern && va[31]) ? "R10" : "R3";
      end
    end
  endfunction

  task automatic doLookup(input logic [31:0] va, input logic [1:0] acc, input logic kern);
    logic [1:0]  ef;
    logic [31:0] ep;
    string       tag;
    model(va, acc, kern, ef, ep, tag);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqAccess = acc; reqKernel = kern;
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " rspValid"}, {31'b0, rspValid}, 32'd1);
    chk({tag, " fault"}, {30'b0, rspFault}, {30'b0, ef});
    chk((ef != 2'd0) ? "R9 paddr" : {tag, " paddr"}, rspPaddr, ep);
  endtask

  task automatic doFill(input logic [18:0] vpn, input logic [18:0] pfn, input logic [2:0] perm,
                        input logic alsoReq);
    @(negedge clk);
    fillEn = 1'b1; fillVpn = vpn; fillPfn = pfn; fillPerm = perm;
    reqValid = alsoReq; reqVaddr = {vpn, 13'h0}; reqKernel = 1'b1; reqAccess = 2'd0;
    #1;
    chk("R2 ready low on fill", {31'b0, reqReady}, 32'd0);
    @(negedge clk);
    fillEn = 1'b0; reqValid = 1'b0;
    if (alsoReq) chk("R2 no rsp when blocked", {31'b0, rspValid}, 32'd0);
    mVpn[mPtr] = vpn; mPfn[mPtr] = pfn; mPerm[mPtr] = perm; mValid[mPtr] = 1'b1;
    mPtr = (mPtr + 1) % 8;
  endtask

  task automatic doFlush(input logic withFill);
    @(negedge clk);
    flushEn = 1'b1; fillEn = withFill; fillVpn = 19'h00abc; fillPfn = 19'h1; fillPerm = 3'b111;
    #1;
    chk("R2 ready low on flush", {31'b0, reqReady}, 32'd0);
    @(negedge clk);
    flushEn = 1'b0; fillEn = 1'b0;
    for (int i = 0; i < 8; i++) mValid[i] = 1'b0;
    mPtr = 0;
  endtask

  function automatic logic [18:0] sweepVpn(input int i);
    return (i[0] ? 19'h40000 : 19'h0) | 19'(i * 19'h123 + 5);
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) mValid[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 rspValid after reset", {31'b0, rspValid}, 32'd0);
    chk("R1 ready after reset", {31'b0, reqReady}, 32'd1);
    doLookup(32'h0000_2000, 2'd0, 1'b1);   // R1 empty -> miss
    doLookup(32'h8000_4000, 2'd0, 1'b1);   // R1
    @(negedge clk);
    chk("R2 rspValid drops", {31'b0, rspValid}, 32'd0);

    // R7 fill all slots, every permission pattern
    for (int i = 0; i < 8; i++)
      doFill(sweepVpn(i), 19'h70000 ^ 19'(i * 19'h0a5), 3'(i), i[1]);

    // full sweep: R3 R4 R6 R10
    for (int i = 0; i < 8; i++)
      for (int a = 0; a < 4; a++)
        for (int k = 0; k < 2; k++)
          doLookup({sweepVpn(i), 13'((i * 13'h3e1 + a * 7 + k) & 13'h1fff)}, 2'(a), k[0]);

    // R5 misses in both halves, R6 user high without a slot
    doLookup(32'h0123_4567, 2'd0, 1'b1);
    doLookup(32'hF000_1111, 2'd2, 1'b1);
    doLookup(32'h0123_4567, 2'd1, 1'b0);
    doLookup(32'hF000_1111, 2'd0, 1'b0);

    // R7 ninth fill evicts the first
    doFill(19'h01111, 19'h02222, 3'b111, 1'b0);
    doLookup({sweepVpn(0), 13'h0010}, 2'd0, 1'b1);   // R7 evicted -> miss
    doLookup({19'h01111, 13'h1abc}, 2'd1, 1'b1);     // R7 new slot hits
    doLookup({sweepVpn(2), 13'h0777}, 2'd0, 1'b1);   // R7 survivor

    // R8 flush wins over simultaneous fill
    doFlush(1'b1);
    doLookup({19'h00abc, 13'h0}, 2'd0, 1'b1);
    doLookup({19'h01111, 13'h5}, 2'd0, 1'b1);
    // R8 pointer back at slot 0: nine fills then the first is gone
    for (int i = 0; i < 9; i++)
      doFill(19'h00200 + 19'(i), 19'h03000 + 19'(i), 3'b101, 1'b0);
    doLookup({19'h00200, 13'h0042}, 2'd0, 1'b1);     // R8 evicted
    doLookup({19'h00201, 13'h0042}, 2'd2, 1'b1);     // R8 survivor exec ok
    doLookup({19'h00208, 13'h1fff}, 2'd1, 1'b1);     // R4 write denied

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule